// File: doc/BRIEF.md
# Exponential Pitch-to-Tuning-Word Converter

This block turns a linear pitch code, taken from a 1 V/octave control input, into the tuning word of a phase-accumulator oscillator. Each new code arrives with a one-cycle valid strobe. The block multiplies the code by 1.25 so that one octave spans exactly 256 steps. It then splits the scaled value into two parts. The upper part is a whole-octave count. The lower byte is a position within the octave.

The lower byte addresses a ROM of 256 mantissas. Each mantissa is the base tuning word (the word for code 0, about 20 Hz at a 62.5 kHz sample rate) multiplied by 2^(k/256). The ROM contents are computed when the design is elaborated. The octave count then shifts the mantissa left. If the shift would exceed 24 bits, the result saturates.

The result is registered and flagged by a one-cycle done strobe. New codes arrive only a few hundred times a second. Even so, the three-stage pipeline accepts a new code on every cycle.

Top module: `expo_tune_conv`

## Requirements
- R1: The scaled pitch equals floor(code × 5 / 4), using the 11-bit code. Its bits [11:8] form the octave count and its bits [7:0] form the fraction index.
- R2: The mantissa for fraction index k equals round(BASE_WORD × 2^(k/256)), where BASE_WORD defaults to 5369.
- R3: The tuning word equals the mantissa shifted left by the octave count. It is never below BASE_WORD.
- R4: If the shifted value exceeds 2^24−1, the tuning word is 2^24−1 (16777215).
- R5: `word_done` is high in the third cycle after the edge that samples `pitch_valid`, and only then. It lasts one cycle per accepted code, and back-to-back codes are accepted.
- R6: With the default base, every tuning word is within 0.5 % of BASE_WORD × 2^(code/204.8).
- R7: While `rst` is high, `word_done` is 0 and `tune_word` is 0 from the next edge on.
- R8: `tune_word` keeps its value in every cycle in which `word_done` is low. A cycle with `pitch_valid` low has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pitch_valid | input | 1 | Strobe: a new pitch code is present |
| pitch_code | input | 11 | Linear pitch code, 204.8 codes per octave |
| word_done | output | 1 | One-cycle strobe: a new tuning word is ready |
| tune_word | output | 24 | Registered oscillator tuning word |

## Verification
The latency assertion assumes that `pitch_valid` stays low while reset is held. A small counter in the checker keeps that assertion off until three clean cycles have passed. The bench drives the strobe only after reset is released. It drives both strobe and code half a cycle away from the sampling edge.

The lower-bound assertion assumes the default width of the octave count, so a shift never pushes the mantissa out of range. To reach saturation, the bench uses a second instance with a larger base. That instance is checked only by the bench's own model.

// File: rtl/expo_tune_pkg.sv
package expo_tune_pkg;
    localparam int CODE_W   = 11;
    localparam int FRAC_W   = 8;
    localparam int OCT_W    = 4;
    localparam int SCALED_W = FRAC_W + OCT_W;
    localparam int WORD_W   = 24;
    localparam int ENTRIES  = 1 << FRAC_W;

    typedef struct packed {
        logic              vld;
        logic [OCT_W-1:0]  oct;
        logic [FRAC_W-1:0] frac;
    } scaled_stage_t;

    // Rounded base * 2^(k / ENTRIES), evaluated at elaboration
    function automatic longint mantissa_of(input int k, input int base);
        real r;
        r = real'(base) * (2.0 ** (real'(k) / real'(ENTRIES)));
        return longint'($rtoi(r + 0.5));
    endfunction
endpackage

// File: rtl/pitch_scaler.sv
module pitch_scaler
    import expo_tune_pkg::*;
#(
    parameter int SCALE_NUM   = 5,
    parameter int SCALE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] in_code,
    output scaled_stage_t     out_stage
);
    localparam int PROD_W = CODE_W + $clog2(SCALE_NUM + 1);

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] shifted;
    logic [SCALED_W-1:0] scaled;

    always_comb begin
        product = PROD_W'(in_code) * PROD_W'(SCALE_NUM);
        shifted = product >> SCALE_SHIFT;
        scaled  = shifted[SCALED_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_stage <= '0;
        end else begin
            out_stage.vld  <= in_vld;
            out_stage.oct  <= scaled[SCALED_W-1:FRAC_W];
            out_stage.frac <= scaled[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/exp_frac_rom.sv
module exp_frac_rom
    import expo_tune_pkg::*;
#(
    parameter int BASE_WORD = 5369,
    parameter int MANT_W    = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  scaled_stage_t     in_stage,
    output logic              out_vld,
    output logic [OCT_W-1:0]  out_oct,
    output logic [MANT_W-1:0] out_mant
);
    logic [MANT_W-1:0] table_w [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        localparam longint VAL = mantissa_of(k, BASE_WORD);
        assign table_w[k] = VAL[MANT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_oct  <= '0;
            out_mant <= '0;
        end else begin
            out_vld  <= in_stage.vld;
            out_oct  <= in_stage.oct;
            out_mant <= table_w[in_stage.frac];
        end
    end
endmodule

// File: rtl/octave_shifter.sv
module octave_shifter
    import expo_tune_pkg::*;
#(
    parameter int MANT_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [OCT_W-1:0]  in_oct,
    input  logic [MANT_W-1:0] in_mant,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int WIDE_W = MANT_W + (1 << OCT_W) - 1;

    logic [WIDE_W-1:0] wide;
    logic [WORD_W-1:0] clipped;

    assign wide = WIDE_W'(in_mant) << in_oct;

    if (WIDE_W > WORD_W) begin : g_sat
        always_comb begin
            if (|wide[WIDE_W-1:WORD_W]) clipped = '1;
            else                        clipped = wide[WORD_W-1:0];
        end
    end else begin : g_nosat
        assign clipped = WORD_W'(wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= in_vld;
            if (in_vld) word <= clipped;
        end
    end
endmodule

// File: rtl/expo_tune_conv.sv
module expo_tune_conv
    import expo_tune_pkg::*;
#(
    parameter int BASE_WORD   = 5369,
    parameter int SCALE_NUM   = 5,
    parameter int SCALE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pitch_valid,
    input  logic [10:0]       pitch_code,
    output logic              word_done,
    output logic [23:0]       tune_word
);
    localparam int MANT_W = $clog2(2 * BASE_WORD) + 1;

    scaled_stage_t     stage1;
    logic              s2_vld;
    logic [OCT_W-1:0]  s2_oct;
    logic [MANT_W-1:0] s2_mant;

    pitch_scaler #(.SCALE_NUM(SCALE_NUM), .SCALE_SHIFT(SCALE_SHIFT)) u_scale (
        .clk(clk), .rst(rst), .in_vld(pitch_valid), .in_code(pitch_code),
        .out_stage(stage1)
    );

    exp_frac_rom #(.BASE_WORD(BASE_WORD), .MANT_W(MANT_W)) u_rom (
        .clk(clk), .rst(rst), .in_stage(stage1),
        .out_vld(s2_vld), .out_oct(s2_oct), .out_mant(s2_mant)
    );

    octave_shifter #(.MANT_W(MANT_W)) u_shift (
        .clk(clk), .rst(rst), .in_vld(s2_vld), .in_oct(s2_oct),
        .in_mant(s2_mant), .done(word_done), .word(tune_word)
    );
endmodule

// File: rtl/expo_tune_checker.sv
module expo_tune_checker #(
    parameter int BASE_WORD = 5369
) (
    input logic        clk,
    input logic        rst,
    input logic        pitch_valid,
    input logic        word_done,
    input logic [23:0] tune_word
);
    logic [1:0] settle;
    logic       seen_edge;

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst)              settle <= '0;
        else if (settle != 3) settle <= settle + 2'd1;
    end

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (settle == 3) |-> (word_done == $past(pitch_valid, 3)));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (settle != 0 && !word_done) |-> $stable(tune_word));

    // R3
    floor_word_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (tune_word >= 24'(BASE_WORD)));

    // R7
    always_ff @(posedge clk) begin
        if (seen_edge && $past(rst)) begin
            reset_clear_chk: assert (!word_done && tune_word == 24'd0);
        end
    end
endmodule

bind expo_tune_conv expo_tune_checker #(.BASE_WORD(BASE_WORD)) u_chk (
    .clk(clk), .rst(rst), .pitch_valid(pitch_valid),
    .word_done(word_done), .tune_word(tune_word)
);

// File: tb/tb_expo_tune_conv.sv
module tb_expo_tune_conv;
    localparam int BASE     = 5369;
    localparam int BASE_BIG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pitch_valid = 1'b0;
    logic [10:0] pitch_code = '0;
    logic        done_a, done_b;
    logic [23:0] word_a, word_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    expo_tune_conv dut (
        .clk(clk), .rst(rst), .pitch_valid(pitch_valid), .pitch_code(pitch_code),
        .word_done(done_a), .tune_word(word_a)
    );

    expo_tune_conv #(.BASE_WORD(BASE_BIG)) dut_sat (
        .clk(clk), .rst(rst), .pitch_valid(pitch_valid), .pitch_code(pitch_code),
        .word_done(done_b), .tune_word(word_b)
    );

    function automatic longint ref_word(input int code, input int base);
        int sc, oct, fr;
        longint m, w;
        sc  = (code * 5) / 4;
        oct = sc / 256;
        fr  = sc % 256;
        m   = longint'($rtoi(real'(base) * (2.0 ** (real'(fr) / 256.0)) + 0.5));
        w   = m << oct;
        if (w > 64'd16777215) w = 16777215;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference pipeline: history of accepted inputs, three edges deep
    bit vh [3];
    int ch [3];
    longint last_a = 0, last_b = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            vh[0] <= 0; vh[1] <= 0; vh[2] <= 0;
        end else begin
            vh[2] <= vh[1]; ch[2] <= ch[1];
            vh[1] <= vh[0]; ch[1] <= ch[0];
            vh[0] <= pitch_valid; ch[0] <= int'(pitch_code);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(done_a == vh[2], "R5 done timing", longint'(done_a), longint'(vh[2]));
            check(done_b == vh[2], "R5 done timing (sat inst)", longint'(done_b), longint'(vh[2]));
            if (vh[2]) begin
                longint ea, eb;
                real ideal, err;
                ea = ref_word(ch[2], BASE);
                eb = ref_word(ch[2], BASE_BIG);
                check(longint'(word_a) == ea, "R1/R2/R3 word", longint'(word_a), ea);
                check(longint'(word_b) == eb, "R4 saturating word", longint'(word_b), eb);
                if (eb == 16777215)
                    check(word_b == 24'hFFFFFF, "R4 clip value", longint'(word_b), 16777215);
                ideal = real'(BASE) * (2.0 ** (real'(ch[2]) / 204.8));
                err = (real'(word_a) - ideal) / ideal;
                if (err < 0.0) err = -err;
                check(err < 0.005, "R6 accuracy", longint'(word_a), longint'($rtoi(ideal)));
            end else begin
                check(longint'(word_a) == last_a, "R8 hold", longint'(word_a), last_a);
                check(longint'(word_b) == last_b, "R8 hold (sat inst)", longint'(word_b), last_b);
            end
        end
        last_a = longint'(word_a);
        last_b = longint'(word_b);
    end

    task automatic send(input int code);
        @(negedge clk);
        pitch_valid = 1'b1;
        pitch_code  = 11'(code);
        @(negedge clk);
        pitch_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pitch_code = 11'(i * 37);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs cleared while reset is held
        check(done_a == 1'b0, "R7 done in reset", longint'(done_a), 0);
        check(word_a == 24'd0, "R7 word in reset", longint'(word_a), 0);
        check(word_b == 24'd0, "R7 word in reset (sat inst)", longint'(word_b), 0);
        rst = 1'b0;
        idle(4);
        // R1 R2 R3 R6: full sweep, back-to-back (R5)
        for (int c = 0; c < 2048; c++) begin
            pitch_valid = 1'b1;
            pitch_code  = 11'(c);
            @(negedge clk);
        end
        pitch_valid = 1'b0;
        idle(6);
        // Octave boundaries and extremes with gaps; R8 on idle cycles
        send(0);    idle(3);
        send(204);  idle(2);
        send(205);  idle(5);
        send(1024); idle(1);
        send(2047); idle(4);
        send(1700); send(1000); idle(6);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule